// File: doc/BRIEF.md
# AUX Reply Status Classifier

This block sits beside a DisplayPort AUX channel engine. When a transaction ends, the engine presents a raw interrupt status word. The block reduces that word to one outcome code and one reply code, and it tags the reply as native or I2C. It raises a one-cycle completion strobe when the word is accepted. On a PHY error it also raises a one-cycle request to clear the engine's interrupt state.

Each cycle in which the status word is non-zero and the busy flag is high counts as one event. If several error bits are set together, a fixed priority picks the result and a warning flag records the overlap. Two cases produce no completion at all: a word that arrives while the engine is idle, and a word that carries no bit the current transaction type considers. In the second case the block pulses an "unexpected" flag instead.

Top module: `aux_reply_classifier`

## Requirements
- R1: Status bit positions are: bit0 done, bit1 PHY error, bit2 NACK-defer, bit3 wrong address, bit4 timeout, bit5 I2C NACK, bit6 I2C defer. Bits above 6 are unrecognised. The result is resolved by priority, highest first: PHY error, NACK-defer, wrong address, timeout, I2C NACK, I2C defer, done.
- R2: `outcome_o` codes are: 0 none, 1 address error, 2 timeout, 3 NACK, 4 defer, 5 NACK-defer, 6 PHY error.
- R3: When `i2c_mode_i` is 0 (native), bits 5 and 6 are never considered.
- R4: In I2C mode, an I2C defer (bit 6) with done (bit 0) in the same word yields NACK (3). Without done it yields defer (4).
- R5: A word that is non-zero while `busy_i` is 1, and that has a considered bit set, produces `done_stb_o` high for exactly the next cycle. A zero word, or any word while `busy_i` is 0, produces no strobe and leaves all held outputs unchanged.
- R6: `hw_clr_o` pulses in the same cycle as a strobe whose outcome is PHY error (6), and at no other time.
- R7: `multi_err_o` is updated with each strobe. It is 1 when more than one bit other than done is set in the accepted word, counting unrecognised bits. The outcome is still taken from the priority.
- R8: `reply_o` = {i2c, kind}, where kind is 0 ACK for none, 2 DEFER for defer, 3 no-reply/timeout for timeout, and 1 NACK for PHY, address, NACK and NACK-defer. Bit 2 of `reply_o` is the transaction's `i2c_mode_i`.
- R9: A word that is non-zero while busy but has no considered bit set gives `unexpected_o` high for exactly the next cycle, no strobe, and unchanged held outputs.
- R10: After reset, `outcome_o`, `reply_o` and all flags are 0. `outcome_o`, `reply_o` and `multi_err_o` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_i | input | STAT_W | Raw status word from the AUX engine |
| i2c_mode_i | input | 1 | 1 = I2C-over-AUX transaction, 0 = native |
| busy_i | input | 1 | A transaction is outstanding |
| done_stb_o | output | 1 | Completion strobe, one cycle |
| outcome_o | output | 3 | Held outcome code |
| reply_o | output | 3 | Held reply {i2c, kind} |
| multi_err_o | output | 1 | Held overlap warning for the last accepted word |
| hw_clr_o | output | 1 | Request to clear the engine's interrupt state |
| unexpected_o | output | 1 | Pulse for a word with no considered bit |

## Verification
The assertions check these properties on every cycle:
- idle or zero words never strobe;
- the held outputs stay stable between strobes;
- the clear request matches PHY-error strobes exactly;
- native replies never carry an I2C-only outcome;
- a strobe and an unexpected pulse never coincide.

Only the bench's scenarios can show the following, by comparing against a behavioural model on every clock:
- that the priority order is right for overlapping bits;
- that a defer combined with done is demoted to NACK;
- that the reply kinds map correctly;
- that overlap counting includes unrecognised bits.

// File: rtl/aux_cls_pkg.sv
// Shared codes and field positions for the AUX reply classifier.
package aux_cls_pkg;

    // Status bit positions (behaviour depends on them)
    localparam int B_DONE   = 0;
    localparam int B_PHY    = 1;
    localparam int B_NDEF   = 2;
    localparam int B_ADDR   = 3;
    localparam int B_TOUT   = 4;
    localparam int B_I2CNAK = 5;
    localparam int B_I2CDEF = 6;
    localparam int N_KNOWN  = 7;

    typedef enum logic [2:0] {
        OC_NONE  = 3'd0,
        OC_ADDR  = 3'd1,
        OC_TOUT  = 3'd2,
        OC_NACK  = 3'd3,
        OC_DEFER = 3'd4,
        OC_NDEF  = 3'd5,
        OC_PHY   = 3'd6
    } outcome_e;

    typedef enum logic [1:0] {
        RK_ACK   = 2'd0,
        RK_NACK  = 2'd1,
        RK_DEFER = 2'd2,
        RK_TOUT  = 2'd3
    } reply_kind_e;

    typedef struct packed {
        logic        i2c;
        reply_kind_e kind;
    } reply_t;

endpackage

// File: rtl/aux_stat_decode.sv
// Priority decoder: turns a raw status word into one outcome.
// Assumes STAT_W >= 7. Purely combinational.
// hit is 0 when no bit considered for the transaction type is set.
// multi counts every set bit except done, unrecognised bits included.
module aux_stat_decode
    import aux_cls_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic [STAT_W-1:0] stat,
    input  logic              i2c_mode,
    output logic              hit,
    output outcome_e          outcome,
    output logic              multi
);
    localparam int CNT_W = $clog2(STAT_W + 1);

    logic [CNT_W-1:0] err_cnt;

    // Count the error bits (everything but done)
    always_comb begin
        err_cnt = '0;
        for (int i = 0; i < STAT_W; i++) begin
            if (i != B_DONE && stat[i]) err_cnt = err_cnt + 1'b1;
        end
    end

    assign multi = (err_cnt > CNT_W'(1));

    // Fixed-priority resolution; I2C-only bits gated by the mode
    always_comb begin
        hit     = 1'b1;
        outcome = OC_NONE;
        if (stat[B_PHY])                       outcome = OC_PHY;
        else if (stat[B_NDEF])                 outcome = OC_NDEF;
        else if (stat[B_ADDR])                 outcome = OC_ADDR;
        else if (stat[B_TOUT])                 outcome = OC_TOUT;
        else if (i2c_mode && stat[B_I2CNAK])   outcome = OC_NACK;
        else if (i2c_mode && stat[B_I2CDEF])   outcome = stat[B_DONE] ? OC_NACK : OC_DEFER;
        else if (stat[B_DONE])                 outcome = OC_NONE;
        else                                   hit     = 1'b0;
    end
endmodule

// File: rtl/aux_reply_map.sv
// Maps an outcome to the reply kind and tags it with the transaction type.
// Timeout carries no reply; it is encoded as its own kind.
module aux_reply_map
    import aux_cls_pkg::*;
(
    input  outcome_e outcome,
    input  logic     i2c_mode,
    output reply_t   reply
);
    // Outcome to reply-kind table
    always_comb begin
        reply.i2c = i2c_mode;
        unique case (outcome)
            OC_NONE:  reply.kind = RK_ACK;
            OC_DEFER: reply.kind = RK_DEFER;
            OC_TOUT:  reply.kind = RK_TOUT;
            default:  reply.kind = RK_NACK;
        endcase
    end
endmodule

// File: rtl/aux_result_reg.sv
// Result register: captures an accepted event and holds it until the next.
// Pulses (strobe, clear, unexpected) last one cycle.
// Synchronous active-low reset.
module aux_result_reg
    import aux_cls_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     accept,
    input  logic     hit,
    input  outcome_e outcome,
    input  reply_t   reply,
    input  logic     multi,
    output logic     stb_q,
    output outcome_e outcome_q,
    output reply_t   reply_q,
    output logic     multi_q,
    output logic     clr_q,
    output logic     unexp_q
);
    logic take;
    assign take = accept && hit;

    // One-cycle event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q   <= 1'b0;
            clr_q   <= 1'b0;
            unexp_q <= 1'b0;
        end else begin
            stb_q   <= take;
            clr_q   <= take && (outcome == OC_PHY);
            unexp_q <= accept && !hit;
        end
    end

    // Held result fields, loaded only on a taken event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outcome_q <= OC_NONE;
            reply_q   <= '0;
            multi_q   <= 1'b0;
        end else if (take) begin
            outcome_q <= outcome;
            reply_q   <= reply;
            multi_q   <= multi;
        end
    end
endmodule

// File: rtl/aux_reply_classifier.sv
// Top: classifies an AUX engine status word into outcome and reply.
// A word is an event in any cycle where it is non-zero and busy is high.
// Results appear one cycle after the event.
module aux_reply_classifier
    import aux_cls_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  logic              i2c_mode_i,
    input  logic              busy_i,
    output logic              done_stb_o,
    output logic [2:0]        outcome_o,
    output logic [2:0]        reply_o,
    output logic              multi_err_o,
    output logic              hw_clr_o,
    output logic              unexpected_o
);
    logic     accept;
    logic     hit;
    logic     multi;
    outcome_e oc;
    outcome_e oc_q;
    reply_t   rp;
    reply_t   rp_q;

    // Event qualification
    assign accept = busy_i && (|stat_i);

    aux_stat_decode #(.STAT_W(STAT_W)) u_dec (
        .stat     (stat_i),
        .i2c_mode (i2c_mode_i),
        .hit      (hit),
        .outcome  (oc),
        .multi    (multi)
    );

    aux_reply_map u_map (
        .outcome  (oc),
        .i2c_mode (i2c_mode_i),
        .reply    (rp)
    );

    aux_result_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .hit       (hit),
        .outcome   (oc),
        .reply     (rp),
        .multi     (multi),
        .stb_q     (done_stb_o),
        .outcome_q (oc_q),
        .reply_q   (rp_q),
        .multi_q   (multi_err_o),
        .clr_q     (hw_clr_o),
        .unexp_q   (unexpected_o)
    );

    assign outcome_o = oc_q;
    assign reply_o   = rp_q;
endmodule

// File: rtl/aux_reply_classifier_chk.sv
// Checker bound to the classifier: cycle-level properties on its ports.
module aux_reply_classifier_chk
    import aux_cls_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] stat_i,
    input logic              i2c_mode_i,
    input logic              busy_i,
    input logic              done_stb_o,
    input logic [2:0]        outcome_o,
    input logic [2:0]        reply_o,
    input logic              multi_err_o,
    input logic              hw_clr_o,
    input logic              unexpected_o
);
    p_idle_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i || stat_i == '0) |=> !done_stb_o && !unexpected_o);

    p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_stb_o && $past(rst_n)) |-> $stable(outcome_o) && $stable(reply_o) && $stable(multi_err_o));

    p_clr_on_phy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_o == (done_stb_o && outcome_o == 3'd6));

    p_native_no_i2c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb_o && !reply_o[2]) |-> (outcome_o != 3'd3 && outcome_o != 3'd4));

    p_stb_unexp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_stb_o, unexpected_o}));

    p_timeout_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb_o |-> ((reply_o[1:0] == 2'd3) == (outcome_o == 3'd2)));

    p_defer_needs_i2c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb_o && outcome_o == 3'd4) |-> reply_o == 3'b110);
endmodule

bind aux_reply_classifier aux_reply_classifier_chk #(.STAT_W(STAT_W)) u_chk (.*);

// File: tb/test_aux_reply_classifier.sv
module test_aux_reply_classifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] stat = '0;
    logic       i2c = 1'b0;
    logic       busy = 1'b0;
    logic       stb, multi, clr, unexp;
    logic [2:0] oc, rp;

    int total = 0;
    int fails = 0;

    // model state
    int  m_oc = 0, m_kind = 0, m_i2c = 0, m_multi = 0;
    bit  m_stb = 0, m_clr = 0, m_unexp = 0;

    always #2 clk = ~clk;

    aux_reply_classifier #(.STAT_W(8)) i_aux_reply_classifier (
        .clk(clk), .rst_n(rst_n), .stat_i(stat), .i2c_mode_i(i2c), .busy_i(busy),
        .done_stb_o(stb), .outcome_o(oc), .reply_o(rp), .multi_err_o(multi),
        .hw_clr_o(clr), .unexpected_o(unexp));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: returns -1 when nothing considered is set
    function automatic int ref_outcome(input logic [7:0] w, input bit is_i2c);
        if (w[1]) return 6;
        if (w[2]) return 5;
        if (w[3]) return 1;
        if (w[4]) return 2;
        if (is_i2c && w[5]) return 3;
        if (is_i2c && w[6]) return w[0] ? 3 : 4;
        if (w[0]) return 0;
        return -1;
    endfunction

    function automatic int ref_kind(input int o);
        case (o)
            0: return 0;
            4: return 2;
            2: return 3;
            default: return 1;
        endcase
    endfunction

    task automatic compare(input string tag);
        chk(stb == m_stb, {tag, " strobe R5"}, stb, m_stb);
        chk(int'(oc) == m_oc, {tag, " outcome R1/R2"}, oc, m_oc);
        chk(int'(rp) == (m_i2c * 4 + m_kind), {tag, " reply R8"}, rp, m_i2c * 4 + m_kind);
        chk(int'(multi) == m_multi, {tag, " multi R7"}, multi, m_multi);
        chk(clr == m_clr, {tag, " clear R6"}, clr, m_clr);
        chk(unexp == m_unexp, {tag, " unexpected R9"}, unexp, m_unexp);
    endtask

    task automatic step(input logic [7:0] w, input bit is_i2c, input bit bz, input string tag);
        int o;
        int cnt;
        @(negedge clk);
        stat = w; i2c = is_i2c; busy = bz;
        @(posedge clk);
        #1;
        o = ref_outcome(w, is_i2c);
        cnt = 0;
        for (int k = 1; k < 8; k++) if (w[k]) cnt++;
        m_stb = 0; m_clr = 0; m_unexp = 0;
        if (bz && w != 0) begin
            if (o < 0) m_unexp = 1;
            else begin
                m_stb = 1; m_oc = o; m_kind = ref_kind(o); m_i2c = is_i2c;
                m_multi = (cnt > 1); m_clr = (o == 6);
            end
        end
        compare(tag);
    endtask

    initial begin
        #(4 * 150000);
        fails++; total++;
        $display("FAIL watchdog R5 act=hung exp=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("reset R10");
        @(negedge clk); rst_n = 1'b1;
        // single bits, native and I2C
        step(8'h01, 0, 1, "native done R2");
        step(8'h01, 1, 1, "i2c done R8");
        step(8'h02, 0, 1, "phy R6");
        step(8'h04, 1, 1, "nack-defer R2");
        step(8'h08, 0, 1, "addr R2");
        step(8'h10, 1, 1, "timeout R8");
        step(8'h20, 1, 1, "i2c nack R1");
        step(8'h40, 1, 1, "i2c defer alone R4");
        step(8'h41, 1, 1, "i2c defer with done R4");
        step(8'h20, 0, 1, "native ignores i2c nack R3");
        step(8'h41, 0, 1, "native defer+done acks R3");
        step(8'h80, 1, 1, "unknown bit R9");
        step(8'h00, 1, 1, "zero word R5");
        step(8'h02, 1, 0, "not busy R5");
        step(8'h00, 0, 0, "hold R10");
        step(8'h1F, 1, 1, "overlap priority R7");
        step(8'hA1, 0, 1, "done+unknown overlap R7");
        step(8'h61, 1, 1, "i2c nack over defer R1");
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] w;
            w = 8'($urandom());
            if (n % 5 == 0) w = 8'(1 << (n % 8)) | 8'(n[0]);
            step(w, bit'($urandom() & 1), ($urandom() % 6) != 0, "random R1");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule